// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Frame Scan Sequencer

This block produces the refresh scan for a 40-row by 101-column dot-matrix panel driven at a 1:40 multiplex ratio. It runs on the display oscillator clock. Each frame lasts 3072 clocks. It walks a one-hot row select from the top row to the bottom row. For every row it reads the row's pixel bits for all columns out of an external display RAM. It then applies one of four display modes and presents one on/off bit per column. A polarity flag flips from frame to frame, so an analogue output stage can alternate the drive and keep the panel free of DC. A one-clock strobe marks the first row of each frame.

The RAM holds five banks of byte-wide column entries. Row `r` lives in bank `r/8` at bit `r mod 8` of every byte. Reads go through a plain request port: a request in one cycle must be answered on `rd_data` at the following clock. The port carries no back-pressure, so the RAM must always accept a request and always meet the one-cycle latency. Each read word holds two neighbouring column bytes, so one row is fetched in 51 reads. The block prefetches the row that comes next while the current row is shown, and it switches columns and row select together at the row boundary. When the sleep input is high, or while reset completes, every output stays at its idle (off) level and the scan stops.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `rst` is high, and for the first two clock edges after it falls, `row_sel`, `col_data`, `frame_pol` and `frame_start` are all zero, whatever the value of `sleep`.
- R2: When `sleep` is sampled high at a clock edge, all four outputs are zero after that edge, and they stay zero while `sleep` remains high.
- R3: After `sleep` is sampled low, the block spends one edge leaving idle and then 77 priming clocks with outputs idle. `frame_start` and row 0 first appear after the 78th edge counted from the first edge that samples `sleep` low.
- R4: In steady scan a frame is 3072 clocks long. Rows 0 to 31 each last 77 clocks and rows 32 to 39 each last 76 clocks.
- R5: During scan, `row_sel` is one-hot (bit `r` = row `r`) and advances from row 0 to row 39, then wraps back to row 0.
- R6: `frame_start` is high for exactly one clock, in the first clock that row 0 is selected.
- R7: `frame_pol` is 0 during the first frame after leaving idle and inverts at every later frame start.
- R8: For row `r` the block reads bank `r/8` and uses bit `r mod 8`. Byte `k` (`rd_data[8k+7:8k]`) of read word `w` holds column `2w+k`. `rd_word` is always below 51, and `rd_data` is taken at the clock after the request.
- R9: The mode `{show_data, mode_alt}` decides the column bits: 2'b00 makes all columns off, 2'b10 shows the RAM bit, 2'b01 turns all columns on, and 2'b11 shows the inverted RAM bit.
- R10: The mode is sampled only at row boundaries. A mode change within a row leaves `col_data` unchanged until the next row starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down request; forces idle outputs and stops the scan |
| show_data | input | 1 | Mode bit selecting data-driven display |
| mode_alt | input | 1 | Mode bit selecting all-on or inverted display |
| rd_en | output | 1 | RAM read request |
| rd_bank | output | 3 | RAM bank of the requested read |
| rd_word | output | 6 | Column-pair index of the requested read |
| rd_data | input | 16 | Two column bytes, returned the clock after the request |
| row_sel | output | 40 | One-hot row select |
| col_data | output | 101 | Per-column on/off bits for the selected row |
| frame_pol | output | 1 | Drive polarity of the current frame |
| frame_start | output | 1 | One-clock pulse on the first clock of row 0 |

## Verification
The hardest states to reach from the ports are the ones around wake-up. These are the priming row after sleep falls, a sleep request that lands in the middle of a row, and a reset that comes mid-frame. All three need a long run of scanning before the stimulus can be placed in the right cycle. The bench holds a behavioural model that counts ticks and rows and rebuilds every column bit straight from its own RAM image, and it compares the model against all outputs on every clock. Directed waits for `frame_start` and for particular rows let the bench place sleep, mode changes and reset at chosen points inside a row. The RAM image is rewritten while the block sleeps, so the prefetch must reload fresh data once the block wakes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } scan_state_e;
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int NUM_ROWS   = 40,
  parameter int FRAME_CLKS = 3072,
  localparam int ROW_W     = $clog2(NUM_ROWS),
  localparam int BASE      = FRAME_CLKS / NUM_ROWS,
  localparam int EXTRA     = FRAME_CLKS % NUM_ROWS,
  localparam int TICK_W    = $clog2(BASE + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  output scan_state_e         state,
  output logic [TICK_W-1:0]   tick,
  output logic [ROW_W-1:0]    fetch_row,
  output logic                period_end,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                frame_start,
  output logic                frame_pol
);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W-1:0]  LONG_ROWS = ROW_W'(EXTRA);
  localparam logic [TICK_W-1:0] LONG_END  = TICK_W'(BASE);
  localparam logic [TICK_W-1:0] SHORT_END = TICK_W'(BASE - 1);

  logic [ROW_W-1:0]  row_idx;
  logic [ROW_W-1:0]  next_row;
  logic [TICK_W-1:0] last_tick;

  // Rows below LONG_ROWS (and the priming period) take one extra clock.
  always_comb begin
    next_row   = (row_idx == LAST_ROW) ? '0 : row_idx + 1'b1;
    last_tick  = (state == ST_PRIME || row_idx < LONG_ROWS) ? LONG_END : SHORT_END;
    period_end = (state != ST_IDLE) && (tick == last_tick);
    fetch_row  = (state == ST_PRIME) ? '0 : next_row;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state       <= ST_IDLE;
      tick        <= '0;
      row_idx     <= '0;
      row_sel     <= '0;
      frame_start <= 1'b0;
      frame_pol   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state       <= ST_PRIME;
          tick        <= '0;
          row_idx     <= '0;
          frame_start <= 1'b0;
        end
        ST_PRIME: begin
          if (period_end) begin
            state       <= ST_RUN;
            tick        <= '0;
            row_idx     <= '0;
            row_sel     <= NUM_ROWS'(1);
            frame_start <= 1'b1;
          end else begin
            tick        <= tick + 1'b1;
            frame_start <= 1'b0;
          end
        end
        default: begin
          if (period_end) begin
            row_idx     <= next_row;
            tick        <= '0;
            row_sel     <= NUM_ROWS'(1) << next_row;
            frame_start <= (next_row == '0);
            if (next_row == '0) frame_pol <= ~frame_pol;
          end else begin
            tick        <= tick + 1'b1;
            frame_start <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int NUM_ROWS      = 40,
  parameter int NUM_COLS      = 101,
  parameter int BANK_ROWS     = 8,
  parameter int COLS_PER_READ = 2,
  parameter int TICK_W        = 7,
  localparam int ROW_W        = $clog2(NUM_ROWS),
  localparam int BANKS        = (NUM_ROWS + BANK_ROWS - 1) / BANK_ROWS,
  localparam int BANK_W       = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int BIT_W        = $clog2(BANK_ROWS),
  localparam int NUM_WORDS    = (NUM_COLS + COLS_PER_READ - 1) / COLS_PER_READ,
  localparam int WORD_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int DATA_W       = 8 * COLS_PER_READ
) (
  input  logic                clk,
  input  logic                rst,
  input  scan_state_e         state,
  input  logic [TICK_W-1:0]   tick,
  input  logic [ROW_W-1:0]    fetch_row,
  output logic                rd_en,
  output logic [BANK_W-1:0]   rd_bank,
  output logic [WORD_W-1:0]   rd_word,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [NUM_COLS-1:0] shadow
);
  localparam logic [TICK_W-1:0] WORDS_T = TICK_W'(NUM_WORDS);
  localparam logic [ROW_W-1:0]  BROWS_R = ROW_W'(BANK_ROWS);

  logic              cap_vld;
  logic [WORD_W-1:0] cap_word;
  logic [BIT_W-1:0]  cap_bit;
  logic [BIT_W-1:0]  req_bit;

  // Reads occupy the first NUM_WORDS ticks of every scan period.
  always_comb begin
    rd_en   = (state != ST_IDLE) && (tick < WORDS_T);
    rd_word = WORD_W'(tick);
    rd_bank = BANK_W'(fetch_row / BROWS_R);
    req_bit = BIT_W'(fetch_row % BROWS_R);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_word <= '0;
      cap_bit  <= '0;
    end else begin
      cap_vld  <= rd_en;
      cap_word <= rd_word;
      cap_bit  <= req_bit;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam int WIDX = c / COLS_PER_READ;
    localparam int BSEL = c % COLS_PER_READ;
    always_ff @(posedge clk) begin
      if (rst)
        shadow[c] <= 1'b0;
      else if (cap_vld && cap_word == WORD_W'(WIDX))
        shadow[c] <= rd_data[BSEL*8 + int'(cap_bit)];
    end
  end
endmodule

// File: rtl/lcd_scan_colmode.sv
module lcd_scan_colmode #(
  parameter int NUM_COLS = 101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                load,
  input  logic                show_data,
  input  logic                mode_alt,
  input  logic [NUM_COLS-1:0] shadow,
  output logic [NUM_COLS-1:0] col_data
);
  logic [NUM_COLS-1:0] shaped;

  always_comb begin
    unique case ({show_data, mode_alt})
      2'b10:   shaped = shadow;
      2'b01:   shaped = '1;
      2'b11:   shaped = ~shadow;
      default: shaped = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold)
      col_data <= '0;
    else if (load)
      col_data <= shaped;
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int NUM_ROWS      = 40,
  parameter int NUM_COLS      = 101,
  parameter int FRAME_CLKS    = 3072,
  parameter int BANK_ROWS     = 8,
  parameter int COLS_PER_READ = 2,
  localparam int ROW_W        = $clog2(NUM_ROWS),
  localparam int BANKS        = (NUM_ROWS + BANK_ROWS - 1) / BANK_ROWS,
  localparam int BANK_W       = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int NUM_WORDS    = (NUM_COLS + COLS_PER_READ - 1) / COLS_PER_READ,
  localparam int WORD_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int DATA_W       = 8 * COLS_PER_READ,
  localparam int TICK_W       = $clog2(FRAME_CLKS / NUM_ROWS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep,
  input  logic                show_data,
  input  logic                mode_alt,
  output logic                rd_en,
  output logic [BANK_W-1:0]   rd_bank,
  output logic [WORD_W-1:0]   rd_word,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic [NUM_COLS-1:0] col_data,
  output logic                frame_pol,
  output logic                frame_start
);
  logic [1:0]          rst_pipe;
  logic                hold;
  scan_state_e         scan_state;
  logic [TICK_W-1:0]   tick;
  logic [ROW_W-1:0]    fetch_row;
  logic                period_end;
  logic [NUM_COLS-1:0] shadow;

  // Two-clock reset completion before sleep is honoured.
  always_ff @(posedge clk) begin
    if (rst) rst_pipe <= 2'b11;
    else     rst_pipe <= {rst_pipe[0], 1'b0};
  end
  assign hold = sleep | (|rst_pipe);

  lcd_scan_timing #(
    .NUM_ROWS   (NUM_ROWS),
    .FRAME_CLKS (FRAME_CLKS)
  ) u_timing (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .state       (scan_state),
    .tick        (tick),
    .fetch_row   (fetch_row),
    .period_end  (period_end),
    .row_sel     (row_sel),
    .frame_start (frame_start),
    .frame_pol   (frame_pol)
  );

  lcd_scan_fetch #(
    .NUM_ROWS      (NUM_ROWS),
    .NUM_COLS      (NUM_COLS),
    .BANK_ROWS     (BANK_ROWS),
    .COLS_PER_READ (COLS_PER_READ),
    .TICK_W        (TICK_W)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .state     (scan_state),
    .tick      (tick),
    .fetch_row (fetch_row),
    .rd_en     (rd_en),
    .rd_bank   (rd_bank),
    .rd_word   (rd_word),
    .rd_data   (rd_data),
    .shadow    (shadow)
  );

  lcd_scan_colmode #(
    .NUM_COLS (NUM_COLS)
  ) u_colmode (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .load      (period_end),
    .show_data (show_data),
    .mode_alt  (mode_alt),
    .shadow    (shadow),
    .col_data  (col_data)
  );
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int NUM_ROWS  = 40,
  parameter int NUM_COLS  = 101,
  parameter int NUM_WORDS = 51,
  parameter int WORD_W    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                sleep,
  input logic                rd_en,
  input logic [WORD_W-1:0]   rd_word,
  input logic [NUM_ROWS-1:0] row_sel,
  input logic [NUM_COLS-1:0] col_data,
  input logic                frame_pol,
  input logic                frame_start
);
  assert_row_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));

  assert_row_advance_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(row_sel) != '0 && row_sel != '0 && row_sel != $past(row_sel)) |->
      (row_sel == {$past(row_sel[NUM_ROWS-2:0]), $past(row_sel[NUM_ROWS-1])}));

  assert_strobe_row0_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> row_sel[0]);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  assert_sleep_idle_R2: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (row_sel == '0 && col_data == '0 && !frame_start && !frame_pol));

  assert_pol_flip_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_pol != $past(frame_pol)) |-> (frame_start || row_sel == '0));

  assert_word_range_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_word) < NUM_WORDS));

  assert_cols_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (row_sel != '0 && $stable(row_sel)) |-> $stable(col_data));
endmodule

bind lcd_scan_seq lcd_scan_chk #(
  .NUM_ROWS  (NUM_ROWS),
  .NUM_COLS  (NUM_COLS),
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep       (sleep),
  .rd_en       (rd_en),
  .rd_word     (rd_word),
  .row_sel     (row_sel),
  .col_data    (col_data),
  .frame_pol   (frame_pol),
  .frame_start (frame_start)
);

// File: tb/lcd_scan_seq_bench.sv
module lcd_scan_seq_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sleep = 1'b0;
  logic         show_data = 1'b1;
  logic         mode_alt = 1'b0;
  logic         rd_en;
  logic [2:0]   rd_bank;
  logic [5:0]   rd_word;
  logic [15:0]  rd_data = '0;
  logic [39:0]  row_sel;
  logic [100:0] col_data;
  logic         frame_pol;
  logic         frame_start;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 0;
  bit done = 0;

  logic [7:0] mem [0:4][0:100];

  always #2 clk = ~clk;

  lcd_scan_seq u_lcd_scan_seq (
    .clk(clk), .rst(rst), .sleep(sleep), .show_data(show_data), .mode_alt(mode_alt),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_word(rd_word), .rd_data(rd_data),
    .row_sel(row_sel), .col_data(col_data), .frame_pol(frame_pol), .frame_start(frame_start)
  );

  // RAM model: one-clock read latency, two column bytes per word (R8)
  always @(posedge clk) begin
    if (rd_en) begin
      for (int k = 0; k < 2; k++) begin
        int col;
        col = int'(rd_word) * 2 + k;
        rd_data[k*8 +: 8] <= (col < 101 && rd_bank < 5) ? mem[rd_bank][col] : 8'h00;
      end
    end
  end

  task automatic fill(int seed);
    for (int b = 0; b < 5; b++)
      for (int c = 0; c < 101; c++)
        mem[b][c] = 8'((b * 53 + c * 29 + seed) ^ (c * seed));
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_st = 0, m_tick = 0, m_row = 0, m_cnt = 2;
  logic [39:0]  e_row = '0;
  logic [100:0] e_col = '0;
  logic e_pol = 0, e_str = 0;

  function automatic logic [100:0] exp_cols(int r);
    logic [100:0] v;
    for (int c = 0; c < 101; c++) begin
      logic b;
      b = mem[r/8][c][r%8];
      case ({show_data, mode_alt})
        2'b10:   v[c] = b;
        2'b11:   v[c] = ~b;
        2'b01:   v[c] = 1'b1;
        default: v[c] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic model_idle();
    m_st = 0; m_tick = 0; m_row = 0;
    e_row = '0; e_col = '0; e_pol = 0; e_str = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 2;
      model_idle();
    end else if (sleep || m_cnt > 0) begin
      if (m_cnt > 0) m_cnt--;
      model_idle();
    end else begin
      case (m_st)
        0: begin m_st = 1; m_tick = 0; e_str = 0; end
        1: begin
          if (m_tick == 76) begin
            m_st = 2; m_row = 0; m_tick = 0;
            e_row = 40'd1; e_col = exp_cols(0); e_str = 1;
          end else begin m_tick++; e_str = 0; end
        end
        default: begin
          int len;
          len = (m_row < 32) ? 77 : 76;
          if (m_tick == len - 1) begin
            m_row = (m_row + 1) % 40; m_tick = 0;
            e_row = 40'd1 << m_row; e_col = exp_cols(m_row);
            e_str = (m_row == 0);
            if (m_row == 0) e_pol = ~e_pol;
          end else begin m_tick++; e_str = 0; end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R5 row_sel", 128'(row_sel), 128'(e_row));
      chk("R9 R8 col_data", 128'(col_data), 128'(e_col));
      chk("R7 frame_pol", 128'(frame_pol), 128'(e_pol));
      chk("R6 frame_start", 128'(frame_start), 128'(e_str));
    end
  end

  task automatic idle_chk(string tag);
    chk(tag, 128'({row_sel, col_data, frame_pol, frame_start}), 128'(0));
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    logic [100:0] snap;
    fill(7);
    @(posedge clk);
    cmp_en = 1;
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst = 1'b0;
    sleep = 1'b1;
    @(negedge clk); idle_chk("R1 first edge after reset");
    sleep = 1'b0;
    @(negedge clk); idle_chk("R1 second edge after reset");

    // R4: frame length and row lengths
    wait_strobe();
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
    chk("R4 frame length", 128'(n), 128'(3072));
    n = 0;
    while (row_sel[0]) begin @(negedge clk); n++; end
    chk("R4 long row length", 128'(n), 128'(77));
    while (!row_sel[39]) @(negedge clk);
    n = 0;
    while (row_sel[39]) begin @(negedge clk); n++; end
    chk("R4 short row length", 128'(n), 128'(76));

    // R10: mid-row mode change has no effect until the next row
    repeat (20) @(negedge clk);
    snap = col_data;
    show_data = 1'b1; mode_alt = 1'b1;
    @(negedge clk);
    chk("R10 cols after mid-row change", 128'(col_data), 128'(snap));
    repeat (1500) @(negedge clk);
    show_data = 1'b0; mode_alt = 1'b1;
    repeat (900) @(negedge clk);
    chk("R9 all-on mode", 128'(col_data), 128'({101{1'b1}}));
    show_data = 1'b0; mode_alt = 1'b0;
    repeat (900) @(negedge clk);
    chk("R9 blank mode", 128'(col_data), 128'(0));
    show_data = 1'b1; mode_alt = 1'b0;

    // R2, R3: sleep mid-row, new RAM image, wake
    repeat (333) @(negedge clk);
    sleep = 1'b1;
    @(negedge clk); idle_chk("R2 outputs after sleep");
    fill(91);
    repeat (10) @(negedge clk);
    idle_chk("R2 outputs during sleep");
    sleep = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start && n < 200);
    chk("R3 wake to first row", 128'(n), 128'(78));
    chk("R7 first frame polarity", 128'(frame_pol), 128'(0));
    @(negedge clk);
    wait_strobe();
    chk("R7 second frame polarity", 128'(frame_pol), 128'(1));

    // R1: reset in mid-scan
    repeat (1234) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); idle_chk("R1 reset mid-scan");
    rst = 1'b0;
    @(negedge clk); idle_chk("R1 edge one after mid-scan reset");
    @(negedge clk); idle_chk("R1 edge two after mid-scan reset");
    wait_strobe();
    repeat (500) @(negedge clk);
    report();
  end
endmodule